// File: doc/BRIEF.md
# Alternate-Space Load Reply Merger

This block joins the replies of two alternate-space load responders into one return path for a four-thread core. The first responder is the existing trap and control unit. The second is an added internal-register unit. Both responders deliver a valid, a thread number and a 64-bit data word in the W2 stage. The block picks the reply that owns the cycle and steers its data into the load-bypass slot of the thread that issued the load. Every other slot keeps its own miscellaneous bypass data.

Each slot has a bypass register. The register captures the slot's bypass value on the clock edge where the slot is selected. The block also holds the alternate-space decode, which marks an ASI number as handled internally. That decode accepts the new ASI number 0x1A along with the numbers the legacy decode already accepts.

At most one reply may arrive per cycle. If both responders assert valid in the same cycle, the block raises a sticky error flag.

Top module: `asi_reply_merge`

## Requirements
- R1: For each thread n, `byp_sel[n]` is 1 exactly when (`legacy_vld` or `aux_vld`) is 1 and `merged_tid` equals n. Otherwise it is 0, so `byp_sel` never has more than one bit set.
- R2: `merged_tid` equals `aux_tid` while `aux_vld` is 1. Otherwise it equals `legacy_tid`.
- R3: For the selected thread, the data slice is `aux_data` while `aux_vld` is 1 and `legacy_data` otherwise. Thread n owns bits [n*64 +: 64] of `byp_data`, `misc_data` and `slot_q`.
- R4: For every thread whose `byp_sel` bit is 0, the `byp_data` slice equals that thread's `misc_data` slice.
- R5: `asi_internal` is 1 for ASI numbers 0x1A, 0x20 and 0x4F, and 0 for every other 8-bit value.
- R6: On a rising edge where `byp_sel[n]` is 1, the `slot_q` slice of thread n takes that cycle's `byp_data` slice. On every other edge the slice keeps its value.
- R7: A synchronous reset (`rst` high at a rising edge) clears all of `slot_q` and clears `collide_err`.
- R8: `collide_err` goes to 1 on the edge after a cycle in which `legacy_vld` and `aux_vld` are both 1. It then stays 1 until reset. Under legal traffic it stays 0.
- R9: With neither valid high, `byp_sel` is 0, every `byp_data` slice equals its `misc_data` slice, and no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| legacy_vld | input | 1 | Reply valid from the trap/control unit (W2) |
| legacy_tid | input | 2 | Thread of the legacy reply |
| legacy_data | input | 64 | Legacy reply data |
| aux_vld | input | 1 | Reply valid from the internal-register unit (W2) |
| aux_tid | input | 2 | Thread of the internal-register reply |
| aux_data | input | 64 | Internal-register reply data |
| misc_data | input | 256 | Per-thread miscellaneous bypass data |
| asi_num | input | 8 | ASI number to classify |
| asi_internal | output | 1 | ASI number is handled internally |
| byp_sel | output | 4 | One-hot-or-zero per-thread bypass select |
| merged_tid | output | 2 | Thread number of the winning reply |
| byp_data | output | 256 | Per-thread bypass data |
| slot_q | output | 256 | Per-thread bypass registers |
| collide_err | output | 1 | Sticky flag: both responders replied in one cycle |

## Verification
A wrong selection shows at the ports in the same cycle. The wrong `byp_sel` bit is set, or a `byp_data` slice carries reply data where misc data belongs, or misc data where reply data belongs. A slot register that loads wrongly, or fails to hold, shows in `slot_q` one edge later. A fault in the sticky error flag is visible one edge after a collision and on every cycle after that. The bench keeps its own model of all four slots, so a corruption in any slot is caught on the next comparison, even if that slot is not the one being written.

// File: rtl/asi_merge_pkg.sv
package asi_merge_pkg;
   localparam int ASI_W = 8;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_LEGACY = 2'd1,
      SRC_AUX    = 2'd2
   } reply_src_e;

   function automatic logic asi_eq(input logic [ASI_W-1:0] a, input logic [ASI_W-1:0] b);
      return a == b;
   endfunction
endpackage

// File: rtl/asi_internal_decode.sv
module asi_internal_decode
   import asi_merge_pkg::*;
#(
   parameter int                       NUM_LEGACY  = 2,
   parameter logic [NUM_LEGACY*ASI_W-1:0] LEGACY_LIST = 16'h4F20,
   parameter logic [ASI_W-1:0]         NEW_ASI     = 8'h1A
) (
   input  logic [ASI_W-1:0] asi_num,
   output logic             is_internal
);
   logic [NUM_LEGACY:0] hit;

   assign hit[NUM_LEGACY] = asi_eq(asi_num, NEW_ASI);

   for (genvar k = 0; k < NUM_LEGACY; k++) begin : g_legacy
      assign hit[k] = asi_eq(asi_num, LEGACY_LIST[k*ASI_W +: ASI_W]);
   end

   assign is_internal = |hit;
endmodule

// File: rtl/reply_arbiter.sv
module reply_arbiter
   import asi_merge_pkg::*;
#(
   parameter int TID_W  = 2,
   parameter int DATA_W = 64
) (
   input  logic              legacy_vld,
   input  logic [TID_W-1:0]  legacy_tid,
   input  logic [DATA_W-1:0] legacy_data,
   input  logic              aux_vld,
   input  logic [TID_W-1:0]  aux_tid,
   input  logic [DATA_W-1:0] aux_data,
   output logic              any_vld,
   output reply_src_e        src,
   output logic [TID_W-1:0]  win_tid,
   output logic [DATA_W-1:0] win_data
);
   always_comb begin
      if (aux_vld)         src = SRC_AUX;
      else if (legacy_vld) src = SRC_LEGACY;
      else                 src = SRC_NONE;
   end

   assign any_vld  = legacy_vld | aux_vld;
   assign win_tid  = aux_vld ? aux_tid  : legacy_tid;
   assign win_data = aux_vld ? aux_data : legacy_data;
endmodule

// File: rtl/bypass_slot.sv
module bypass_slot #(
   parameter int DATA_W  = 64,
   parameter int TID_W   = 2,
   parameter int SLOT_ID = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              any_vld,
   input  logic [TID_W-1:0]  win_tid,
   input  logic [DATA_W-1:0] win_data,
   input  logic [DATA_W-1:0] misc,
   output logic              sel,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] q
);
   localparam logic [TID_W-1:0] MY_TID = TID_W'(SLOT_ID);

   assign sel  = any_vld & (win_tid == MY_TID);
   assign dout = sel ? win_data : misc;

   always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (sel) q <= dout;
   end
endmodule

// File: rtl/asi_reply_merge.sv
module asi_reply_merge
   import asi_merge_pkg::*;
#(
   parameter int               NUM_THREADS = 4,
   parameter int               DATA_W      = 64,
   parameter logic [ASI_W-1:0] NEW_ASI     = 8'h1A,
   parameter int               NUM_LEGACY  = 2,
   parameter logic [NUM_LEGACY*ASI_W-1:0] LEGACY_LIST = 16'h4F20,
   localparam int              TID_W       = $clog2(NUM_THREADS),
   localparam int              BUS_W       = NUM_THREADS * DATA_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   legacy_vld,
   input  logic [TID_W-1:0]       legacy_tid,
   input  logic [DATA_W-1:0]      legacy_data,
   input  logic                   aux_vld,
   input  logic [TID_W-1:0]       aux_tid,
   input  logic [DATA_W-1:0]      aux_data,
   input  logic [BUS_W-1:0]       misc_data,
   input  logic [ASI_W-1:0]       asi_num,
   output logic                   asi_internal,
   output logic [NUM_THREADS-1:0] byp_sel,
   output logic [TID_W-1:0]       merged_tid,
   output logic [BUS_W-1:0]       byp_data,
   output logic [BUS_W-1:0]       slot_q,
   output logic                   collide_err
);
   if (NUM_THREADS < 2 || (1 << TID_W) != NUM_THREADS) begin : g_bad_threads
      $error("NUM_THREADS must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic              any_vld;
   reply_src_e        src;
   logic [DATA_W-1:0] win_data;

   asi_internal_decode #(
      .NUM_LEGACY (NUM_LEGACY),
      .LEGACY_LIST(LEGACY_LIST),
      .NEW_ASI    (NEW_ASI)
   ) i_decode (
      .asi_num    (asi_num),
      .is_internal(asi_internal)
   );

   reply_arbiter #(
      .TID_W (TID_W),
      .DATA_W(DATA_W)
   ) i_arb (
      .legacy_vld (legacy_vld),
      .legacy_tid (legacy_tid),
      .legacy_data(legacy_data),
      .aux_vld    (aux_vld),
      .aux_tid    (aux_tid),
      .aux_data   (aux_data),
      .any_vld    (any_vld),
      .src        (src),
      .win_tid    (merged_tid),
      .win_data   (win_data)
   );

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
      bypass_slot #(
         .DATA_W (DATA_W),
         .TID_W  (TID_W),
         .SLOT_ID(t)
      ) i_slot (
         .clk     (clk),
         .rst     (rst),
         .any_vld (any_vld),
         .win_tid (merged_tid),
         .win_data(win_data),
         .misc    (misc_data[t*DATA_W +: DATA_W]),
         .sel     (byp_sel[t]),
         .dout    (byp_data[t*DATA_W +: DATA_W]),
         .q       (slot_q[t*DATA_W +: DATA_W])
      );
   end

   logic both_vld;
   assign both_vld = (src == SRC_AUX) & legacy_vld;

   always_ff @(posedge clk) begin
      if (rst)           collide_err <= 1'b0;
      else if (both_vld) collide_err <= 1'b1;
   end
endmodule

// File: rtl/asi_reply_merge_chk.sv
module asi_reply_merge_chk #(
   parameter int NUM_THREADS = 4,
   parameter int DATA_W      = 64,
   parameter int TID_W       = 2,
   parameter int ASI_W       = 8
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          legacy_vld,
   input logic [TID_W-1:0]              legacy_tid,
   input logic                          aux_vld,
   input logic [TID_W-1:0]              aux_tid,
   input logic [ASI_W-1:0]              asi_num,
   input logic                          asi_internal,
   input logic [NUM_THREADS-1:0]        byp_sel,
   input logic [TID_W-1:0]              merged_tid,
   input logic [NUM_THREADS*DATA_W-1:0] byp_data,
   input logic [NUM_THREADS*DATA_W-1:0] slot_q,
   input logic                          collide_err
);
   AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (rst) $onehot0(byp_sel)); // R1
   AST_SEL_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
      ((legacy_vld | aux_vld) == (byp_sel != '0))); // R1
   AST_AUX_TID_WINS: assert property (@(posedge clk) disable iff (rst)
      aux_vld |-> merged_tid == aux_tid); // R2
   AST_LEGACY_TID: assert property (@(posedge clk) disable iff (rst)
      !aux_vld |-> merged_tid == legacy_tid); // R2
   AST_NEW_ASI_DECODE: assert property (@(posedge clk) disable iff (rst)
      asi_num == 8'h1A |-> asi_internal); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      collide_err |=> collide_err); // R8
   AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
      (legacy_vld & aux_vld) |=> collide_err); // R8

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot_chk
      AST_SLOT_LOAD: assert property (@(posedge clk) disable iff (rst)
         byp_sel[t] |=> slot_q[t*DATA_W +: DATA_W] == $past(byp_data[t*DATA_W +: DATA_W])); // R6
      AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
         !byp_sel[t] |=> $stable(slot_q[t*DATA_W +: DATA_W])); // R6
   end
endmodule

bind asi_reply_merge asi_reply_merge_chk #(
   .NUM_THREADS(NUM_THREADS),
   .DATA_W     (DATA_W),
   .TID_W      (TID_W),
   .ASI_W      (asi_merge_pkg::ASI_W)
) i_chk (
   .clk         (clk),
   .rst         (rst),
   .legacy_vld  (legacy_vld),
   .legacy_tid  (legacy_tid),
   .aux_vld     (aux_vld),
   .aux_tid     (aux_tid),
   .asi_num     (asi_num),
   .asi_internal(asi_internal),
   .byp_sel     (byp_sel),
   .merged_tid  (merged_tid),
   .byp_data    (byp_data),
   .slot_q      (slot_q),
   .collide_err (collide_err)
);

// File: tb/test_asi_reply_merge.sv
module test_asi_reply_merge;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 4;
   localparam int DW = 64;

   logic            clk = 1'b0;
   logic            rst;
   logic            legacy_vld, aux_vld;
   logic [1:0]      legacy_tid, aux_tid;
   logic [DW-1:0]   legacy_data, aux_data;
   logic [NT*DW-1:0] misc_data;
   logic [7:0]      asi_num;
   logic            asi_internal;
   logic [NT-1:0]   byp_sel;
   logic [1:0]      merged_tid;
   logic [NT*DW-1:0] byp_data, slot_q;
   logic            collide_err;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model_slot [NT];

   always #(CLK_PERIOD/2) clk = ~clk;

   asi_reply_merge i_asi_reply_merge (
      .clk(clk), .rst(rst),
      .legacy_vld(legacy_vld), .legacy_tid(legacy_tid), .legacy_data(legacy_data),
      .aux_vld(aux_vld), .aux_tid(aux_tid), .aux_data(aux_data),
      .misc_data(misc_data), .asi_num(asi_num), .asi_internal(asi_internal),
      .byp_sel(byp_sel), .merged_tid(merged_tid), .byp_data(byp_data),
      .slot_q(slot_q), .collide_err(collide_err)
   );

   function automatic logic exp_internal(input logic [7:0] a);
      return (a == 8'h1A) || (a == 8'h20) || (a == 8'h4F);
   endfunction

   function automatic logic [1:0] exp_tid();
      return aux_vld ? aux_tid : legacy_tid;
   endfunction

   function automatic logic [NT-1:0] exp_sel();
      logic [NT-1:0] s = '0;
      if (legacy_vld || aux_vld) s[exp_tid()] = 1'b1;
      return s;
   endfunction

   function automatic logic [DW-1:0] exp_byp(input int t);
      if (exp_sel()[t]) return aux_vld ? aux_data : legacy_data;
      return misc_data[t*DW +: DW];
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_comb();
      check("R1 sel", DW'(byp_sel), DW'(exp_sel()));
      check("R2 tid", DW'(merged_tid), DW'(exp_tid()));
      check("R5 decode", DW'(asi_internal), DW'(exp_internal(asi_num)));
      for (int t = 0; t < NT; t++) begin
         if (exp_sel()[t]) check("R3 data", byp_data[t*DW +: DW], exp_byp(t));
         else              check("R4 misc", byp_data[t*DW +: DW], exp_byp(t));
      end
   endtask

   task automatic check_slots(input string req);
      for (int t = 0; t < NT; t++) check(req, slot_q[t*DW +: DW], model_slot[t]);
   endtask

   // Inputs change 1 time unit after a rising edge; combinational outputs are
   // checked just after; slot registers are checked 1 unit after the next edge.
   task automatic cycle(input logic check_err);
      #1;
      check_comb();
      for (int t = 0; t < NT; t++)
         if (exp_sel()[t]) model_slot[t] = exp_byp(t);
      @(posedge clk);
      #1;
      check_slots("R6 slot");
      if (check_err) check("R8 no err", DW'(collide_err), '0);
   endtask

   task automatic rand_inputs(input int mode);
      legacy_vld  = (mode == 1);
      aux_vld     = (mode == 2);
      legacy_tid  = 2'($urandom);
      aux_tid     = 2'($urandom);
      legacy_data = {$urandom, $urandom};
      aux_data    = {$urandom, $urandom};
      for (int t = 0; t < NT; t++) misc_data[t*DW +: DW] = {$urandom, $urandom};
      asi_num     = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'h5EED_1A1A));
      rst = 1'b1;
      rand_inputs(0);
      for (int t = 0; t < NT; t++) model_slot[t] = '0;
      repeat (2) @(posedge clk);
      #1;
      check_slots("R7 reset slots");
      check("R7 reset err", DW'(collide_err), '0);
      rst = 1'b0;

      // Directed: no valid (R9), then the accepted ASI numbers
      rand_inputs(0);
      asi_num = 8'h1A;
      cycle(1'b1);
      check("R9 idle sel", DW'(byp_sel), '0);
      rand_inputs(0); asi_num = 8'h20; cycle(1'b1);
      rand_inputs(0); asi_num = 8'h4F; cycle(1'b1);
      rand_inputs(0); asi_num = 8'h1B; cycle(1'b1);

      // Directed: each responder writes every thread
      for (int t = 0; t < NT; t++) begin
         rand_inputs(1); legacy_tid = 2'(t); aux_tid = 2'(NT-1-t); cycle(1'b1);
         rand_inputs(2); aux_tid = 2'(t); legacy_tid = 2'(NT-1-t); cycle(1'b1);
      end

      // Constrained random legal traffic
      for (int i = 0; i < 400; i++) begin
         rand_inputs(int'($urandom_range(0, 2)));
         cycle(1'b1);
      end

      // Directed collision: R8 flag sets and stays
      rand_inputs(0);
      legacy_vld = 1'b1; aux_vld = 1'b1;
      cycle(1'b0);
      check("R8 err set", DW'(collide_err), 1);
      rand_inputs(0);
      cycle(1'b0);
      check("R8 err sticky", DW'(collide_err), 1);

      // Reset clears everything (R7)
      rand_inputs(1);
      rst = 1'b1;
      @(posedge clk);
      #1;
      for (int t = 0; t < NT; t++) model_slot[t] = '0;
      check_slots("R7 reset slots");
      check("R7 reset err", DW'(collide_err), '0);
      rst = 1'b0;
      rand_inputs(0);
      cycle(1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule